// File: doc/BRIEF.md
# Fault Input Interrupt Control Register

This block turns one asynchronous external fault signal into a prioritized interrupt request. An 8-bit control/status register configures it. Software chooses which input sense counts as active: a low level or falling edge, or a high level or rising edge. Software also chooses whether the block latches edges or follows the level, enables or masks the request, and assigns a 3-bit priority level.

In edge mode the status bit is sticky. Software removes it by writing a one to a self-clearing clear bit. In level mode the status bit follows the synchronized, polarity-corrected input. The request leaves the block together with its level code. A level code of zero keeps the source silent. An arbiter outside the block compares requests from many such sources.

Top module: `irqsrc_ctrl`

## Requirements
- R1: After reset, with `fault_in` held high, `rdata` reads 0x00 and `irq_req` and `irq_level` are 0.
- R2: Register bits: 7 = polarity, 6 = edge mode, 5 = status (read-only, written value ignored), 4 = enable, 3 = clear (always reads 0), 2..0 = level. Bits 7, 6, 4 and 2..0 read back as written.
- R3: In level mode (bit 6 = 0), status is 1 while the input is at its active level: low when polarity = 0, high when polarity = 1. It follows the input within four clocks.
- R4: In edge mode, an active edge sets status: falling when polarity = 0, rising when polarity = 1. Status stays set after the input returns to its inactive state.
- R5: A write with bit 3 = 1 and bit 6 = 1 clears the status. A write with bit 3 = 1 in level mode leaves the status unchanged.
- R6: A write that changes only the polarity while in edge mode does not set status, whether or not the clear bit is written.
- R7: `irq_req` is 1 exactly when enable = 1, status = 1 and level != 0. `irq_level` then equals the level field, and it is 0 when `irq_req` is 0.
- R8: A level field of 0 never produces a request, even when enable and status are both 1.
- R9: The register changes only in cycles with `sel` = 1 and `we` = 1. Cycles without both leave every configuration bit unchanged.
- R10: Switching from level mode to edge mode starts with status 0, even if the input is at its active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Register select from the address decoder |
| we | input | 1 | Write strobe, used when `sel` is high |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Register read-back byte |
| fault_in | input | 1 | Asynchronous fault input |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Priority level of the request, 0 when idle |

## Verification
The assertions assume that `sel`, `we` and `wdata` are synchronous to `clk`. They also assume that `fault_in`, although asynchronous, does not change in the same cycle as a clear write that it would collide with. The bench drives every input on the falling clock edge. After each random input change it waits four cycles, so the synchronizer has settled before the next register access. In this way a genuine edge never lands in the same cycle as a clear. The random mix covers polarity flips in edge mode with and without the clear bit, and every level code including zero.

// File: rtl/irqsrc_pkg.sv
// Package irqsrc_pkg
// Shared widths, bit positions and the configuration record of the
// fault-input interrupt control register. Bit positions are fixed by
// software, so they are localparams and not module parameters.
package irqsrc_pkg;

    localparam int unsigned REG_W    = 8;
    localparam int unsigned LVL_W    = 3;
    localparam int unsigned POL_BIT  = 7;
    localparam int unsigned MODE_BIT = 6;
    localparam int unsigned STAT_BIT = 5;
    localparam int unsigned EN_BIT   = 4;
    localparam int unsigned CLR_BIT  = 3;

    // Software-visible configuration held in flops
    typedef struct packed {
        logic             pol;        // 1: high/rising active, 0: low/falling
        logic             edge_mode;  // 1: latch edges, 0: follow level
        logic             en;         // request enable
        logic [LVL_W-1:0] lvl;        // priority level, 0 = silent
    } src_cfg_t;

    // Polarity correction: 1 when the raw sample is the active sense
    function automatic logic is_active(input logic raw, input logic pol);
        return pol ? raw : ~raw;
    endfunction

endpackage

// File: rtl/irqsrc_sync.sv
// Module irqsrc_sync
// Multi-stage synchronizer for one asynchronous input bit.
// Assumes: STAGES >= 2. RST_VAL is loaded into every stage while rst_n
// is low, so the synchronized value starts out in a known state.
module irqsrc_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage samples the asynchronous pin
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[i] <= RST_VAL;
                else        chain_q[i] <= din;
            end
        end else begin : g_rest
            // Later stages let any metastability settle
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[i] <= RST_VAL;
                else        chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/irqsrc_cfg.sv
// Module irqsrc_cfg
// Holds the writable configuration fields and decodes a register write.
// Assumes: wr_en is already qualified by select and write strobe. The
// status bit position in the write data is ignored, because status is
// read-only. The clear bit is not stored: it leaves as a one-cycle pulse.
module irqsrc_cfg
    import irqsrc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output src_cfg_t         cfg,
    output logic             wr_clr,
    output logic             wr_mode
);

    src_cfg_t cfg_q;
    logic     wdata_unused;

    assign wdata_unused = wdata[STAT_BIT];

    // Load the configuration fields on a qualified write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q.pol       <= wdata[POL_BIT];
            cfg_q.edge_mode <= wdata[MODE_BIT];
            cfg_q.en        <= wdata[EN_BIT];
            cfg_q.lvl       <= wdata[LVL_W-1:0];
        end
    end

    // Clear request and the mode that the current write establishes
    always_comb begin
        wr_clr  = wr_en & wdata[CLR_BIT];
        wr_mode = wr_en ? wdata[MODE_BIT] : cfg_q.edge_mode;
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/irqsrc_status.sv
// Module irqsrc_status
// Produces the interrupt status from the synchronized input.
// Edge detection compares the current and the previous raw samples,
// both corrected with the current polarity. A polarity write alone
// therefore never looks like an edge. The edge latch is held at 0 in
// level mode and whenever the resulting mode is level. A clear written
// in edge mode takes priority over an edge seen in the same cycle.
// Assumes: pin_sync is already synchronous to clk.
module irqsrc_status
    import irqsrc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pin_sync,
    input  src_cfg_t cfg,
    input  logic     wr_clr,
    input  logic     wr_mode,
    output logic     status
);

    logic prev_q;
    logic latch_q;
    logic act_now;
    logic act_prev;
    logic edge_hit;

    // Remember the previous raw sample for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= pin_sync;
    end

    // Correct both samples with the same, current polarity
    always_comb begin
        act_now  = is_active(pin_sync, cfg.pol);
        act_prev = is_active(prev_q, cfg.pol);
        edge_hit = act_now & ~act_prev;
    end

    // Sticky edge latch: mode exit or clear wins over a new edge
    always_ff @(posedge clk) begin
        if (!rst_n)                          latch_q <= 1'b0;
        else if (!wr_mode || !cfg.edge_mode) latch_q <= 1'b0;
        else if (wr_clr)                     latch_q <= 1'b0;
        else if (edge_hit)                   latch_q <= 1'b1;
    end

    // Select the status source by mode
    always_comb begin
        status = cfg.edge_mode ? latch_q : act_now;
    end

endmodule

// File: rtl/irqsrc_ctrl.sv
// Module irqsrc_ctrl (top)
// Control/status register for one external fault interrupt source.
// Assumes: sel, we and wdata are synchronous to clk. fault_in may be
// asynchronous. Read data is always presented; the surrounding bus
// decides when to capture it.
module irqsrc_ctrl
    import irqsrc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             fault_in,
    output logic             irq_req,
    output logic [LVL_W-1:0] irq_level
);

    src_cfg_t cfg;
    logic     wr_en;
    logic     wr_clr;
    logic     wr_mode;
    logic     pin_sync;
    logic     status;

    assign wr_en = sel & we;

    irqsrc_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (fault_in),
        .dout  (pin_sync)
    );

    irqsrc_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wdata   (wdata),
        .cfg     (cfg),
        .wr_clr  (wr_clr),
        .wr_mode (wr_mode)
    );

    irqsrc_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_sync (pin_sync),
        .cfg      (cfg),
        .wr_clr   (wr_clr),
        .wr_mode  (wr_mode),
        .status   (status)
    );

    // Assemble the read-back byte; the clear position always reads 0
    always_comb begin
        rdata                = '0;
        rdata[POL_BIT]       = cfg.pol;
        rdata[MODE_BIT]      = cfg.edge_mode;
        rdata[STAT_BIT]      = status;
        rdata[EN_BIT]        = cfg.en;
        rdata[CLR_BIT]       = 1'b0;
        rdata[LVL_W-1:0]     = cfg.lvl;
    end

    // Gate the request by enable, status and a nonzero level
    always_comb begin
        irq_req   = cfg.en & status & (cfg.lvl != '0);
        irq_level = irq_req ? cfg.lvl : '0;
    end

endmodule

// File: rtl/irqsrc_ctrl_chk.sv
// Module irqsrc_ctrl_chk
// Port-level checker bound into irqsrc_ctrl.
// Assumes: inputs are synchronous to clk, apart from fault_in.
module irqsrc_ctrl_chk
    import irqsrc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             sel,
    input logic             we,
    input logic [REG_W-1:0] wdata,
    input logic [REG_W-1:0] rdata,
    input logic             irq_req,
    input logic [LVL_W-1:0] irq_level
);

    assert_clr_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[CLR_BIT] == 1'b0);

    assert_req_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_level == rdata[LVL_W-1:0]) && rdata[EN_BIT] && rdata[STAT_BIT]);

    assert_idle_level_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> irq_level == '0);

    assert_zero_level_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[LVL_W-1:0] == '0) |-> !irq_req);

    assert_no_write_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && we) |=> $stable({rdata[POL_BIT], rdata[MODE_BIT], rdata[EN_BIT], rdata[LVL_W-1:0]}));

    assert_edge_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && we && wdata[CLR_BIT] && wdata[MODE_BIT]) |=> !rdata[STAT_BIT]);

    assert_enter_edge_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && we && wdata[MODE_BIT] && !rdata[MODE_BIT]) |=> !rdata[STAT_BIT]);

endmodule

bind irqsrc_ctrl irqsrc_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .we        (we),
    .wdata     (wdata),
    .rdata     (rdata),
    .irq_req   (irq_req),
    .irq_level (irq_level)
);

// File: tb/irqsrc_ctrl_tb.sv
module irqsrc_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0;
    logic       we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       fault_in = 1'b1;
    logic       irq_req;
    logic [2:0] irq_level;

    int checks = 0;
    int bad = 0;

    // Reference state kept by the bench
    logic       m_pol = 0, m_mode = 0, m_en = 0, m_latch = 0;
    logic [2:0] m_lvl = 0;

    always #5 clk = ~clk;

    irqsrc_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .we(we), .wdata(wdata),
        .rdata(rdata), .fault_in(fault_in), .irq_req(irq_req), .irq_level(irq_level)
    );

    function automatic logic act(input logic raw, input logic pol);
        return pol ? raw : ~raw;
    endfunction

    function automatic logic exp_status();
        return m_mode ? m_latch : act(fault_in, m_pol);
    endfunction

    function automatic logic [7:0] exp_rdata();
        return {m_pol, m_mode, exp_status(), m_en, 1'b0, m_lvl};
    endfunction

    function automatic logic exp_req();
        return m_en & exp_status() & (m_lvl != 3'd0);
    endfunction

    task automatic check(input string tag, input int act_v, input int exp_v);
        checks++;
        if (act_v != exp_v) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " rdata"}, rdata, exp_rdata());
        check({tag, " irq_req"}, irq_req, exp_req());
        check({tag, " irq_level"}, irq_level, exp_req() ? m_lvl : 3'd0);
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        sel = 1; we = 1; wdata = d;
        @(negedge clk);
        sel = 0; we = 0;
        if (!d[6] || d[3]) m_latch = 0;
        m_pol = d[7]; m_mode = d[6]; m_en = d[4]; m_lvl = d[2:0];
    endtask

    task automatic set_pin(input logic v);
        logic old = fault_in;
        @(negedge clk);
        fault_in = v;
        if (m_mode && act(v, m_pol) && !act(old, m_pol)) m_latch = 1;
        repeat (4) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd11));
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        check("R1 reset rdata", rdata, 8'h00);
        check("R1 reset irq_req", irq_req, 0);
        check("R1 reset irq_level", irq_level, 0);

        // R2: readback, status bit ignored, clear reads zero
        wr(8'hFF);
        check("R2 readback", rdata, 8'hD7);
        wr(8'h25);
        check("R2 status not writable", rdata, 8'h05);

        // R9: no write without both strobes
        @(negedge clk); sel = 0; we = 1; wdata = 8'hFF;
        @(negedge clk); sel = 1; we = 0;
        @(negedge clk); sel = 0; we = 0;
        check("R9 ignored write", rdata, 8'h05);

        // R3: level mode, active low then active high
        wr(8'h17);
        set_pin(0);
        check("R3 active low", rdata, 8'h37);
        check("R7 request", irq_req, 1);
        check("R7 level", irq_level, 7);
        wr(8'h97);
        check("R3 pol high inactive", rdata[5], 0);
        set_pin(1);
        check("R3 active high", rdata[5], 1);

        // R8: level 0 silences
        wr(8'h90);
        check("R8 status", rdata[5], 1);
        check("R8 no request", irq_req, 0);

        // R5: clear in level mode has no effect
        wr(8'h9B);
        check("R5 level clear ignored", rdata[5], 1);

        // R10: entering edge mode with active input starts clear
        wr(8'hD3);
        check("R10 edge entry clear", rdata[5], 0);

        // R4: rising edge latches, stays after fall
        set_pin(0);
        check("R4 no edge yet", rdata[5], 0);
        set_pin(1);
        check("R4 rising latched", rdata[5], 1);
        set_pin(0);
        check("R4 sticky", rdata[5], 1);
        check("R7 edge request", irq_level, 3);

        // R5: clear in edge mode
        wr(8'hDB);
        check("R5 edge clear", rdata[5], 0);

        // R6: polarity flip in edge mode, input low: with and without clear
        wr(8'h53);
        repeat (3) @(negedge clk);
        check("R6 flip no clear", rdata[5], 0);
        wr(8'hDB);
        wr(8'h5B);
        repeat (3) @(negedge clk);
        check("R6 flip with clear", rdata[5], 0);

        // R4: falling edge with polarity 0
        set_pin(1);
        set_pin(0);
        check("R4 falling latched", rdata[5], 1);
        check_all("R7 directed");

        // Random mix of R3 R4 R5 R6 R7 R8 R10
        for (int i = 0; i < 400; i++) begin
            if ($urandom % 2) wr(8'($urandom));
            set_pin(1'($urandom));
            check_all("R7 random");
        end

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule